// File: doc/BRIEF.md
# Shortened-Cycle Counter Built on a Loadable Binary Counter

This block produces a short repeating count from a 4-bit synchronous binary up-counter. The counter can load a value in parallel, can increment, and has a count enable and a carry-out. A small control stage watches the count. When the count reaches the last value of the chosen cycle, the control stage drives the counter's load input, so the preset goes in on the next clock edge instead of the next binary value. Every change, including the wrap back to the start, happens on the clock edge. No value appears briefly and is then cleared.

Two cycles are available. The first runs 0 through 6 and then returns to 0, so it repeats every seven clocks. The second starts from 9 after reset, runs up to 14 and then reloads 9, so it repeats every six clocks. The select input is read only while reset is held. A single-cycle wrap output marks each clock in which the reload takes place. The block can serve as a clock-enable divider or as a sequencing pacer, using either the count or the wrap pulse.

Top module: `modn_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 if `mode_sel` is 0 (seven-state cycle) and 9 if `mode_sel` is 1 (six-state cycle).
- R2: In the seven-state cycle, with `en` high, the count steps 0,1,2,3,4,5,6 and then returns to 0 on the following edge.
- R3: In the six-state cycle, with `en` high, the count steps 9,10,11,12,13,14 and then returns to 9 on the following edge.
- R4: `wrap` is high in exactly those cycles where `en` is high, `rst` is low and the count is at the last value of the cycle (6 or 14). It is low in every other cycle.
- R5: While `en` is low, the count holds its value through any number of edges and `wrap` stays low, even when the count is at the last value.
- R6: `mode_sel` is captured only while `rst` is high. A change of `mode_sel` outside reset does not alter the sequence until the next reset.
- R7: Reset takes priority over the wrap reload and over incrementing. Reset in a cycle where `wrap` would otherwise fire still gives the R1 value, and `wrap` is low in that cycle.
- R8: In the base counter, load takes priority over increment, and increment over hold. Its carry-out rises only at count 15 with counting enabled. Neither cycle ever reaches 15, so the count never shows 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also captures the cycle select |
| en | input | 1 | Count enable; low freezes the count |
| mode_sel | input | 1 | Cycle select: 0 = seven-state from 0, 1 = six-state from 9 |
| count | output | 4 | Present count value |
| wrap | output | 1 | High in the cycle whose edge reloads the preset |

## Verification
The reload triggered by the last value can fall in the same cycle as a reset request. It can also fall in the same cycle as a drop of the enable. The stimulus table drives the count to 14 and then to 6, and asserts reset with enable high at each of those points. It also holds enable low while the count sits at 14. After the edge, the bench reads the count and compares it with the reset value or the held value. Before the edge, it checks that `wrap` stayed low. A further table row changes the select in mid-run. Reference-model runs with a gapped enable pattern then confirm that neither the count nor the wrap timing drifts.

// File: rtl/modn_pkg.sv
package modn_pkg;

    localparam int CW = 4;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic {
        MODE_SEVEN = 1'b0,
        MODE_SIX   = 1'b1
    } modn_mode_e;

    typedef struct packed {
        logic ld;
        logic inc;
        cnt_t d;
    } ctr_ctl_t;

    localparam cnt_t SEVEN_PRESET = cnt_t'(0);
    localparam cnt_t SEVEN_LAST   = cnt_t'(6);
    localparam cnt_t SIX_PRESET   = cnt_t'(9);
    localparam cnt_t SIX_LAST     = cnt_t'(14);

    function automatic cnt_t preset_of(modn_mode_e m);
        return (m == MODE_SIX) ? SIX_PRESET : SEVEN_PRESET;
    endfunction

    function automatic cnt_t last_of(modn_mode_e m);
        return (m == MODE_SIX) ? SIX_LAST : SEVEN_LAST;
    endfunction

    // Seven-state cycle never holds codes above 6, so bits 2 and 1 suffice.
    function automatic logic at_last(modn_mode_e m, cnt_t q);
        if (m == MODE_SIX)
            return q == SIX_LAST;
        return q[2] & q[1];
    endfunction

endpackage

// File: rtl/modn_bin_ctr.sv
module modn_bin_ctr
    import modn_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_t     rst_val,
    input  ctr_ctl_t ctl,
    output cnt_t     q,
    output logic     co
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= rst_val;
        else if (ctl.ld)
            q <= ctl.d;
        else if (ctl.inc)
            q <= q + cnt_t'(1);
    end

    assign co = ctl.inc & (&q);

    // R8
    ld_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.ld |=> q == $past(ctl.d));

    // R8
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.ld && ctl.inc) |=> q == $past(q) + cnt_t'(1));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.ld && !ctl.inc) |=> $stable(q));

endmodule

// File: rtl/modn_last_detect.sv
module modn_last_detect
    import modn_pkg::*;
(
    input  modn_mode_e mode,
    input  logic       en,
    input  cnt_t       q,
    output ctr_ctl_t   ctl,
    output logic       hit
);

    logic is_last;

    always_comb begin
        is_last = at_last(mode, q);
        hit     = en & is_last;
        ctl.ld  = hit;
        ctl.inc = en;
        ctl.d   = preset_of(mode);
    end

endmodule

// File: rtl/modn_counter.sv
module modn_counter
    import modn_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          mode_sel,
    output logic [CW-1:0] count,
    output logic          wrap
);

    modn_mode_e mode_q;
    modn_mode_e mode_in;
    ctr_ctl_t   ctl;
    cnt_t       q;
    cnt_t       rst_val;
    logic       hit;
    logic       co;

    assign mode_in = modn_mode_e'(mode_sel);
    assign rst_val = preset_of(mode_in);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= mode_in;
    end

    modn_last_detect u_detect (
        .mode (mode_q),
        .en   (en),
        .q    (q),
        .ctl  (ctl),
        .hit  (hit)
    );

    modn_bin_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .rst_val (rst_val),
        .ctl     (ctl),
        .q       (q),
        .co      (co)
    );

    assign count = q;
    assign wrap  = hit & ~rst;

    // R6
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));

    // R2
    seven_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SEVEN) |-> (count <= SEVEN_LAST));

    // R3
    six_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SIX) |-> (count >= SIX_PRESET && count <= SIX_LAST));

    // R4
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> count == preset_of(mode_q));

    // R5
    en_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count));

    // R8
    no_carry_chk: assert property (@(posedge clk) disable iff (rst)
        !co);

endmodule

// File: tb/modn_counter_bench.sv
`timescale 1ns/1ps
module modn_counter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       mode_sel = 1'b0;
    logic [3:0] count;
    logic       wrap;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    modn_counter u_modn_counter (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .mode_sel (mode_sel),
        .count    (count),
        .wrap     (wrap)
    );

    // {rst, en, mode_sel, wrap expected before edge, count expected after edge}
    localparam int NV = 32;
    localparam logic [7:0] VEC [NV] = '{
        8'b1000_0000, // R1 reset, seven-state
        8'b0100_0001, 8'b0100_0010, 8'b0100_0011, // R2
        8'b0100_0100, 8'b0100_0101, 8'b0100_0110,
        8'b0101_0000, // R2 R4 wrap at 6
        8'b0000_0000, // R5 hold
        8'b0110_0001, // R6 select change ignored
        8'b1110_1001, // R1 reset into six-state
        8'b0100_1010, 8'b0100_1011, 8'b0100_1100, // R3, R6 select back to 0 ignored
        8'b0100_1101, 8'b0100_1110,
        8'b0000_1110, // R5 enable low at 14: hold, no wrap
        8'b0101_1001, // R3 R4 wrap at 14
        8'b0100_1010, 8'b0100_1011, 8'b0100_1100, 8'b0100_1101, 8'b0100_1110,
        8'b1100_0000, // R7 reset at 14 with enable
        8'b0100_0001, 8'b0100_0010, 8'b0100_0011,
        8'b0100_0100, 8'b0100_0101, 8'b0100_0110,
        8'b1110_1001, // R7 reset at 6 into six-state
        8'b0100_1010
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_run(input logic six, input int cycles);
        int m;
        @(negedge clk);
        rst = 1'b1; en = 1'b1; mode_sel = six;
        @(posedge clk); #1;
        m = six ? 9 : 0;
        check("R1", count, m);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            rst = 1'b0;
            en = (i % 5) != 3;
            mode_sel = i[0];
            #0.5;
            check("R4", wrap, (en && m == (six ? 14 : 6)) ? 1 : 0);
            if (en) m = (m == (six ? 14 : 6)) ? (six ? 9 : 0) : m + 1;
            @(posedge clk); #1;
            check(six ? "R3" : "R2", count, m);
            check("R8", (count == 15) ? 1 : 0, 0);
        end
    endtask

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            rst = VEC[v][7]; en = VEC[v][6]; mode_sel = VEC[v][5];
            #0.5;
            check("R4 R7 table wrap", wrap, VEC[v][4]);
            @(posedge clk); #1;
            check("R1 R2 R3 R5 R6 table count", count, VEC[v][3:0]);
        end

        // R5: long enable-low stretch parked at 6 in the seven-state cycle
        @(negedge clk); rst = 1'b1; en = 1'b0; mode_sel = 1'b0;
        @(posedge clk); #1;
        check("R1 reset", count, 0);
        @(negedge clk); rst = 1'b0; en = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        check("R2 reach 6", count, 6);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); en = 1'b0;
            #0.5;
            check("R5 wrap low", wrap, 0);
            @(posedge clk); #1;
            check("R5 hold", count, 6);
        end

        model_run(1'b0, 60);
        model_run(1'b1, 60);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule